// File: doc/BRIEF.md
# Rotate-Right Unit with Carry

This block rotates a 32-bit operand to the right by an 8-bit amount and produces the rotated word together with an updated carry flag, as one slice of a small processor's shifter datapath. The bits that leave the low end of the word re-enter at the top, and when flag update is requested the carry takes the last bit that was rotated out.

Amounts of 32 and above are folded back by taking away 32 as often as needed, so every nonzero 8-bit amount acts like an amount from 1 to 32. An amount of 32 leaves the word unchanged. An amount of zero rotates nothing and leaves the carry alone. A request is accepted on any cycle with the valid input high, and its result is registered so that it appears one clock later with the valid output high.

Top module: `ror_carry_unit`

## Requirements
- R1: For an effective amount n from 1 to 31, result bit i equals operand bit (i+n) mod 32. The low n operand bits reappear as the top n result bits.
- R2: With flag update high and a nonzero amount, the carry output equals operand bit n-1, where n is the effective amount. This is the same bit as result bit 31.
- R3: A nonzero amount whose low five bits are zero (32, 64, 96 and so on) acts as a rotation by 32. The result equals the operand, and an updated carry equals operand bit 31.
- R4: An amount above 32 gives the same result and carry as that amount with 32 taken away repeatedly until it lies in 1 to 32. So 33 acts as 1 and 255 acts as 31.
- R5: An amount of 0 returns the operand unchanged and passes the incoming carry through, even with flag update high.
- R6: With flag update low, the carry output equals the incoming carry for every amount.
- R7: The result, carry and valid output are registered one clock after a cycle with the valid input high. The valid output is low after any cycle without a request, and the result and carry then hold their last values.
- R8: A synchronous active-high reset clears the valid output, the result and the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_word | input | 32 | Operand to rotate |
| req_amount | input | 8 | Rotate amount |
| req_setflag | input | 1 | Update the carry from the rotation |
| req_carry | input | 1 | Incoming carry flag |
| rsp_valid | output | 1 | Registered result is from the previous cycle's request |
| rsp_word | output | 32 | Rotated operand |
| rsp_carry | output | 1 | Updated or passed-through carry |

## Verification
A fault in one of the five rotation stages shows at the result on the very next response. The result is wrong for every amount whose binary form uses that stage, and the number of set bits in the word stays the same. A fault in amount folding shows first at the boundary amounts 32, 33, 64 and 255, where the result moves away from the operand or the one-bit reference. A wrong carry choice shows at the same response as a carry that differs from result bit 31 or from the incoming carry. Because there is one register stage, every fault is visible exactly one cycle after the offending request.

// File: rtl/ror_pkg.sv
package ror_pkg;
    parameter int unsigned WORD_W = 32;
    parameter int unsigned AMT_W  = 8;
    localparam int unsigned SEL_W = $clog2(WORD_W);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              carry;
    } rsp_state_t;
endpackage

// File: rtl/ror_amount_fold.sv
module ror_amount_fold #(
    parameter int unsigned AMT_W = 8,
    parameter int unsigned SEL_W = 5
) (
    input  logic [AMT_W-1:0] amount,
    output logic [SEL_W-1:0] stage_sel,
    output logic             is_zero,
    output logic             is_full
);
    // Taking away 32 over and over keeps the low five bits unchanged.
    // A nonzero amount whose low bits are all zero stands for a full turn.
    logic [SEL_W-1:0] low_d;

    always_comb begin
        low_d     = amount[SEL_W-1:0];
        is_zero   = (amount == '0);
        is_full   = !is_zero && (low_d == '0);
        stage_sel = low_d;
    end
endmodule

// File: rtl/ror_log_stages.sv
module ror_log_stages #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SEL_W  = 5
) (
    input  logic [WORD_W-1:0] din,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] lvl [SEL_W+1];

    assign lvl[0] = din;

    for (genvar s = 0; s < SEL_W; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        always_comb begin
            if (sel[s])
                lvl[s+1] = {lvl[s][STEP-1:0], lvl[s][WORD_W-1:STEP]};
            else
                lvl[s+1] = lvl[s];
        end
    end

    assign dout = lvl[SEL_W];
endmodule

// File: rtl/ror_carry_pick.sv
module ror_carry_pick #(
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] rotated,
    input  logic              amount_zero,
    input  logic              setflag,
    input  logic              carry_in,
    output logic              carry_out
);
    // After a right rotation by n the top bit holds operand bit n-1.
    always_comb begin
        if (setflag && !amount_zero)
            carry_out = rotated[WORD_W-1];
        else
            carry_out = carry_in;
    end
endmodule

// File: rtl/ror_carry_unit.sv
module ror_carry_unit
    import ror_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_word,
    input  logic [7:0]        req_amount,
    input  logic              req_setflag,
    input  logic              req_carry,
    output logic              rsp_valid,
    output logic [31:0]       rsp_word,
    output logic              rsp_carry
);
    logic [SEL_W-1:0]  sel_w;
    logic              zero_w;
    logic              full_w;
    logic [WORD_W-1:0] rot_w;
    logic              carry_w;
    rsp_state_t        st_d, st_q;

    ror_amount_fold #(.AMT_W(AMT_W), .SEL_W(SEL_W)) u_fold (
        .amount    (req_amount),
        .stage_sel (sel_w),
        .is_zero   (zero_w),
        .is_full   (full_w)
    );

    ror_log_stages #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_stages (
        .din  (req_word),
        .sel  (sel_w),
        .dout (rot_w)
    );

    ror_carry_pick #(.WORD_W(WORD_W)) u_carry (
        .rotated     (rot_w),
        .amount_zero (zero_w),
        .setflag     (req_setflag),
        .carry_in    (req_carry),
        .carry_out   (carry_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.word  = rot_w;
            st_d.carry = carry_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_word  = st_q.word;
    assign rsp_carry = st_q.carry;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && $stable(rsp_word) && $stable(rsp_carry)));

    // R1
    bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ($countones(rsp_word) == $countones($past(req_word))));

    // R3
    full_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && full_w) |=> (rsp_word == $past(req_word)));

    // R5
    zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_amount == 8'd0) |=>
            (rsp_word == $past(req_word) && rsp_carry == $past(req_carry)));

    // R6
    carry_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_setflag) |=> (rsp_carry == $past(req_carry)));

    // R2
    carry_top_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_setflag && req_amount != 8'd0) |=> (rsp_carry == rsp_word[31]));
endmodule

// File: tb/ror_carry_unit_bench.sv
`timescale 1ns/1ps
module ror_carry_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_word;
    logic [7:0]  req_amount;
    logic        req_setflag;
    logic        req_carry;
    logic        rsp_valid;
    logic [31:0] rsp_word;
    logic        rsp_carry;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ror_carry_unit u_ror_carry_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
        .req_amount(req_amount), .req_setflag(req_setflag), .req_carry(req_carry),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_carry(rsp_carry)
    );

    function automatic int fold_amt(input int a);
        int n = a;
        while (n > 32) n -= 32;
        return n;
    endfunction

    function automatic logic [31:0] ref_word(input logic [31:0] w, input int a);
        logic [31:0] r = w;
        for (int k = 0; k < fold_amt(a); k++) r = {r[0], r[31:1]};
        return r;
    endfunction

    function automatic logic ref_carry(input logic [31:0] w, input int a,
                                       input logic sf, input logic cin);
        logic c = cin;
        logic [31:0] r = w;
        if (sf) begin
            for (int k = 0; k < fold_amt(a); k++) begin
                c = r[0];
                r = {r[0], r[31:1]};
            end
        end
        return c;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] w, input logic [7:0] a,
                          input logic sf, input logic cin);
        string rtag, ctag;
        logic [31:0] ew;
        logic ec;
        @(negedge clk);
        req_valid = 1'b1; req_word = w; req_amount = a;
        req_setflag = sf; req_carry = cin;
        @(negedge clk);
        req_valid = 1'b0;
        ew = ref_word(w, a);
        ec = ref_carry(w, a, sf, cin);
        if (a == 0)                 rtag = "R5";
        else if (a > 32)            rtag = "R4";
        else if (a[4:0] == 5'd0)    rtag = "R3";
        else                        rtag = "R1";
        if (!sf)                    ctag = "R6";
        else if (a == 0)            ctag = "R5";
        else if (a > 32)            ctag = "R4";
        else if (a[4:0] == 5'd0)    ctag = "R3";
        else                        ctag = "R2";
        check("R7", "valid", {31'd0, rsp_valid}, 32'd1);
        check(rtag, "word", rsp_word, ew);
        check(ctag, "carry", {31'd0, rsp_carry}, {31'd0, ec});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held_w;
        logic held_c;
        int seed;
        seed = $urandom(32'h00005eed);
        rst = 1'b1; req_valid = 1'b0; req_word = '0; req_amount = '0;
        req_setflag = 1'b0; req_carry = 1'b0;
        // load non-zero state first so that reset has something to clear
        @(negedge clk); rst = 1'b0;
        run_op(32'hFFFF_FFFF, 8'd0, 1'b0, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        // R8
        check("R8", "valid", {31'd0, rsp_valid}, 32'd0);
        check("R8", "word", rsp_word, 32'd0);
        check("R8", "carry", {31'd0, rsp_carry}, 32'd0);
        rst = 1'b0;

        // directed corners
        run_op(32'h8000_0001, 8'd0,   1'b1, 1'b0);
        run_op(32'h8000_0001, 8'd1,   1'b1, 1'b0);
        run_op(32'h0000_0002, 8'd1,   1'b1, 1'b1);
        run_op(32'h4000_0000, 8'd31,  1'b1, 1'b0);
        run_op(32'h8000_0000, 8'd31,  1'b1, 1'b1);
        run_op(32'h8123_4567, 8'd32,  1'b1, 1'b0);
        run_op(32'h0123_4567, 8'd32,  1'b1, 1'b1);
        run_op(32'h0000_0001, 8'd33,  1'b1, 1'b0);
        run_op(32'hDEAD_BEEF, 8'd64,  1'b1, 1'b0);
        run_op(32'hC000_0000, 8'd255, 1'b1, 1'b0);
        run_op(32'hA5A5_0F0F, 8'd13,  1'b0, 1'b1);
        run_op(32'hA5A5_0F0F, 8'd13,  1'b0, 1'b0);

        // R7: idle cycle keeps values and drops valid
        held_w = rsp_word; held_c = rsp_carry;
        @(negedge clk);
        check("R7", "idle valid", {31'd0, rsp_valid}, 32'd0);
        check("R7", "idle word", rsp_word, held_w);
        check("R7", "idle carry", {31'd0, rsp_carry}, {31'd0, held_c});

        // random mix
        for (int i = 0; i < 400; i++) begin
            run_op($urandom, 8'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule